// File: doc/BRIEF.md
# Subaddress-Mapped Message Bus Sequencer

This block is the back end of a MIL-STD-1553 remote terminal. The protocol state machine hands it the fields of each accepted command word, plus one strobe per valid received data word and one strobe per word the encoder needs to send. The block turns these into single-cycle accesses on a simple processor-style message bus. A receive message produces one write per valid data word. A transmit message produces one read per requested word, and the returned value is handed back to the encoder. No processor or software takes part.

The access address is built from the direction bit, the 5-bit subaddress of the current command and a word index that restarts at zero with every command. The word count field limits how many accesses a message may make. When the state machine flags a message as failed, the block stops all accesses until that message ends. Subaddress 30 is the wraparound subaddress. Its traffic never reaches the message bus: received words go into a built-in 32 x 16 RAM, and transmitted words are read back from that RAM. Everything runs on the one clock that the block shares with the user logic.

Top module: `msgseq_top`

## Requirements
- R1: While reset is held and right after it, `busWrite`, `busRead` and `txWordValid` are low, and `busAddr` and `busDataOut` are zero.
- R2: In a receive message (command direction bit 0) to any subaddress other than 30, each accepted `rxWordValid` strobe produces exactly one one-cycle `busWrite` pulse. The pulse comes in the clock after the strobe, with `busDataOut` equal to the received word. `busWrite` and `busRead` are never high in the same cycle.
- R3: The address of every access is 16 bits wide. Bits 15..11 are zero, bit 10 is the command direction bit (1 = transmit), bits 9..5 are the subaddress and bits 4..0 are the word index. The word index is 0 for the first access after each command and rises by one with each accepted word.
- R4: In a transmit message (direction bit 1) to a subaddress other than 30, each accepted `txWordReq` strobe produces one one-cycle `busRead` pulse in the clock after the strobe. The `busDataIn` value present during that pulse appears on `txWord`, with a one-cycle `txWordValid`, in the clock after it.
- R5: A word count field N from 1 to 31 allows exactly N accesses per message, and a field of 0 allows 32. Word strobes beyond that limit are ignored.
- R6: After `msgError`, no write, read, RAM access or `txWordValid` follows for that message, up to `msgEnd` or the next command. A strobe that arrives in the same cycle as `msgError` is also dropped.
- R7: Word strobes are ignored when no message is open. A strobe whose direction does not match the open command is also ignored, as is any strobe that arrives in the same cycle as `cmdValid`.
- R8: Receive words for subaddress 30 are stored in the internal 32 x 16 RAM at the word index and cause no `busWrite`.
- R9: Transmit requests for subaddress 30 read the internal RAM at the word index and cause no `busRead`. The data appears on `txWord` with `txWordValid` two clocks after the strobe, the same delay as an external read.
- R10: `cmdValid` opens a new message in every state, including a failed message that has not yet ended. The new message resumes accesses from word index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock shared with the user logic |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | One-cycle strobe: a valid command word was accepted |
| cmdTx | input | 1 | Direction of the command, 1 = terminal transmits |
| cmdSubaddr | input | 5 | Subaddress field of the command |
| cmdWordCount | input | 5 | Word count field, 0 means 32 |
| rxWordValid | input | 1 | One-cycle strobe: a valid data word was received |
| rxWord | input | 16 | Received data word |
| txWordReq | input | 1 | One-cycle strobe: the encoder needs the next word |
| msgError | input | 1 | One-cycle strobe: the current message failed |
| msgEnd | input | 1 | One-cycle strobe: the current message ended |
| busAddr | output | 16 | Message bus address |
| busDataOut | output | 16 | Message bus write data |
| busWrite | output | 1 | One-cycle write pulse |
| busRead | output | 1 | One-cycle read pulse |
| busDataIn | input | 16 | Message bus read data, valid while `busRead` is high |
| txWord | output | 16 | Word handed to the encoder |
| txWordValid | output | 1 | One-cycle strobe: `txWord` is valid |

## Verification
The sequencer is driven with receive and transmit messages to ordinary subaddresses using short word counts. This separates a correct address composition and index restart from a stuck or shared index. Full messages with a count field of 0, followed by an extra strobe, tell a 32-word limit apart from a zero limit or an unbounded one. Errors raised in the middle of a message, and new commands that arrive without an end, separate a failure that is held only until the end from one that leaks past a new command or never clears. Wraparound messages written and then read back show that subaddress 30 data makes the round trip through the internal RAM while the message bus stays silent. Strobes with no message open, or with the wrong direction, must leave the bus quiet.

// File: rtl/msgseq_pkg.sv
package msgseq_pkg;

  localparam int SA_W     = 5;
  localparam int IDX_W    = 5;
  localparam int ADDR_USED = 1 + SA_W + IDX_W;

  typedef enum logic [1:0] {
    MSG_IDLE   = 2'd0,
    MSG_ACTIVE = 2'd1,
    MSG_FAILED = 2'd2
  } msgState_t;

  typedef struct packed {
    logic                 extWrite;
    logic                 extRead;
    logic                 wrapWrite;
    logic                 wrapRead;
    logic [ADDR_USED-1:0] addr;
  } seqStrobe_t;

endpackage

// File: rtl/msgseq_wrapram.sv
module msgseq_wrapram #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wrEn) mem[wrIdx] <= wrData;
  end

  assign rdData = mem[rdIdx];

endmodule

// File: rtl/msgseq_ctrl.sv
module msgseq_ctrl
  import msgseq_pkg::*;
#(
  parameter int WRAP_SA = 30
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic             cmdTx,
  input  logic [SA_W-1:0]  cmdSubaddr,
  input  logic [IDX_W-1:0] cmdWordCount,
  input  logic             rxWordValid,
  input  logic             txWordReq,
  input  logic             msgError,
  input  logic             msgEnd,
  output seqStrobe_t       strobe
);
  localparam logic [IDX_W:0]  MAX_WORDS = (IDX_W+1)'(2 ** IDX_W);
  localparam logic [SA_W-1:0] WRAP_CODE = SA_W'(WRAP_SA);

  msgState_t        state;
  logic             curTx;
  logic [SA_W-1:0]  curSa;
  logic [IDX_W:0]   wordIdx;
  logic [IDX_W:0]   wordLimit;

  logic canAccess;
  logic isWrap;
  logic rxTake;
  logic txTake;

  always_comb begin
    canAccess = (state == MSG_ACTIVE) && (wordIdx < wordLimit) &&
                !msgError && !cmdValid;
    isWrap    = (curSa == WRAP_CODE);
    rxTake    = canAccess && rxWordValid && !curTx;
    txTake    = canAccess && txWordReq && curTx;

    strobe.extWrite  = rxTake && !isWrap;
    strobe.wrapWrite = rxTake && isWrap;
    strobe.extRead   = txTake && !isWrap;
    strobe.wrapRead  = txTake && isWrap;
    strobe.addr      = {curTx, curSa, wordIdx[IDX_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= MSG_IDLE;
      curTx     <= 1'b0;
      curSa     <= '0;
      wordIdx   <= '0;
      wordLimit <= '0;
    end else if (cmdValid) begin
      state     <= MSG_ACTIVE;
      curTx     <= cmdTx;
      curSa     <= cmdSubaddr;
      wordIdx   <= '0;
      wordLimit <= (cmdWordCount == '0) ? MAX_WORDS : {1'b0, cmdWordCount};
    end else begin
      if (msgEnd)
        state <= MSG_IDLE;
      else if (msgError && state == MSG_ACTIVE)
        state <= MSG_FAILED;
      if (rxTake || txTake)
        wordIdx <= wordIdx + 1'b1;
    end
  end

  AST_IDX_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    wordIdx <= wordLimit) else $error("index beyond limit"); // R5

  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> (wordIdx == '0)) else $error("index not restarted"); // R3

  AST_FAIL_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (msgError && !cmdValid) |=> !(rxTake || txTake)) else $error("access after error"); // R6

  AST_EXCL_DIR: assert property (@(posedge clk) disable iff (!rstN)
    !(rxTake && txTake)) else $error("both directions taken"); // R2

endmodule

// File: rtl/msgseq_dpath.sv
module msgseq_dpath
  import msgseq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [DATA_W-1:0] rxWord,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busWrite,
  output logic              busRead,
  output logic [DATA_W-1:0] txWord,
  output logic              txWordValid
);
  localparam int PAD_W = ADDR_W - ADDR_USED;

  logic              wrapPend;
  logic [IDX_W-1:0]  wrapIdx;
  logic [DATA_W-1:0] wrapData;

  msgseq_wrapram #(.DATA_W(DATA_W), .IDX_W(IDX_W)) uRam (
    .clk    (clk),
    .wrEn   (strobe.wrapWrite),
    .wrIdx  (strobe.addr[IDX_W-1:0]),
    .wrData (rxWord),
    .rdIdx  (wrapIdx),
    .rdData (wrapData)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busWrite    <= 1'b0;
      busRead     <= 1'b0;
      busAddr     <= '0;
      busDataOut  <= '0;
      wrapPend    <= 1'b0;
      wrapIdx     <= '0;
      txWord      <= '0;
      txWordValid <= 1'b0;
    end else begin
      busWrite <= strobe.extWrite;
      busRead  <= strobe.extRead;
      wrapPend <= strobe.wrapRead;
      if (strobe.extWrite || strobe.extRead)
        busAddr <= {{PAD_W{1'b0}}, strobe.addr};
      if (strobe.extWrite)
        busDataOut <= rxWord;
      if (strobe.wrapRead)
        wrapIdx <= strobe.addr[IDX_W-1:0];
      txWordValid <= busRead || wrapPend;
      if (busRead)
        txWord <= busDataIn;
      else if (wrapPend)
        txWord <= wrapData;
    end
  end

  AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    !(busWrite && busRead)) else $error("write and read together"); // R2

  AST_TX_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    busRead |=> txWordValid) else $error("read data not forwarded"); // R4

  AST_WRAP_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.wrapWrite || strobe.wrapRead) |=> !(busWrite || busRead)) else $error("wrap hit bus"); // R8

  AST_WRAP_TX: assert property (@(posedge clk) disable iff (!rstN)
    wrapPend |=> txWordValid) else $error("wrap data not forwarded"); // R9

endmodule

// File: rtl/msgseq_top.sv
module msgseq_top
  import msgseq_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 16,
  parameter int WRAP_SA = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdTx,
  input  logic [4:0]        cmdSubaddr,
  input  logic [4:0]        cmdWordCount,
  input  logic              rxWordValid,
  input  logic [DATA_W-1:0] rxWord,
  input  logic              txWordReq,
  input  logic              msgError,
  input  logic              msgEnd,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busWrite,
  output logic              busRead,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [DATA_W-1:0] txWord,
  output logic              txWordValid
);
  seqStrobe_t strobe;

  msgseq_ctrl #(.WRAP_SA(WRAP_SA)) uCtrl (
    .clk          (clk),
    .rstN         (rstN),
    .cmdValid     (cmdValid),
    .cmdTx        (cmdTx),
    .cmdSubaddr   (cmdSubaddr),
    .cmdWordCount (cmdWordCount),
    .rxWordValid  (rxWordValid),
    .txWordReq    (txWordReq),
    .msgError     (msgError),
    .msgEnd       (msgEnd),
    .strobe       (strobe)
  );

  msgseq_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .rxWord      (rxWord),
    .busDataIn   (busDataIn),
    .busAddr     (busAddr),
    .busDataOut  (busDataOut),
    .busWrite    (busWrite),
    .busRead     (busRead),
    .txWord      (txWord),
    .txWordValid (txWordValid)
  );

endmodule

// File: tb/msgseq_top_test.sv
module msgseq_top_test;

  localparam logic [15:0] KEY = 16'h5A3C;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cmdValid, cmdTx, rxWordValid, txWordReq, msgError, msgEnd;
  logic [4:0]  cmdSubaddr, cmdWordCount;
  logic [15:0] rxWord, busAddr, busDataOut, busDataIn, txWord;
  logic        busWrite, busRead, txWordValid;

  always #10 clk = ~clk;

  assign busDataIn = busAddr ^ KEY;

  msgseq_top uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdTx(cmdTx),
    .cmdSubaddr(cmdSubaddr), .cmdWordCount(cmdWordCount),
    .rxWordValid(rxWordValid), .rxWord(rxWord), .txWordReq(txWordReq),
    .msgError(msgError), .msgEnd(msgEnd), .busAddr(busAddr),
    .busDataOut(busDataOut), .busWrite(busWrite), .busRead(busRead),
    .busDataIn(busDataIn), .txWord(txWord), .txWordValid(txWordValid)
  );

  typedef struct {
    int          kind;   // 0 write, 1 read, 2 tx data
    logic [15:0] addr;
    logic [15:0] data;
    string       tag;
  } expItem_t;

  expItem_t    expQ[$];
  int          checks = 0;
  int          failures = 0;
  bit          running = 0;
  bit          done = 0;
  string       curTag = "R1";

  bit          mOpen, mTx, mFailed;
  int          mSa, mIdx, mLimit;
  logic [15:0] wrapMem [32];

  task automatic popCmp(int kind, logic [15:0] addr, logic [15:0] data);
    expItem_t e;
    checks++;
    if (expQ.size() == 0) begin
      failures++;
      $display("FAIL %s: unexpected event kind=%0d addr=%h data=%h, expected none",
               curTag, kind, addr, data);
    end else begin
      e = expQ.pop_front();
      if (e.kind != kind || e.addr !== addr || e.data !== data) begin
        failures++;
        $display("FAIL %s: got kind=%0d addr=%h data=%h, expected kind=%0d addr=%h data=%h",
                 e.tag, kind, addr, data, e.kind, e.addr, e.data);
      end
    end
  endtask

  always @(negedge clk) begin
    if (running) begin
      if (busWrite)    popCmp(0, busAddr, busDataOut);
      if (busRead)     popCmp(1, busAddr, 16'h0000);
      if (txWordValid) popCmp(2, 16'h0000, txWord);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doCmd(bit tx, int sa, int wc);
    @(negedge clk);
    cmdValid = 1; cmdTx = tx; cmdSubaddr = 5'(sa); cmdWordCount = 5'(wc);
    @(negedge clk);
    cmdValid = 0;
    mOpen = 1; mFailed = 0; mTx = tx; mSa = sa; mIdx = 0;
    mLimit = (wc == 0) ? 32 : wc;
    idle(2);
  endtask

  function automatic logic [15:0] modelAddr();
    return {5'b0, mTx, 5'(mSa), 5'(mIdx)};
  endfunction

  task automatic doRx(logic [15:0] w);
    if (mOpen && !mFailed && !mTx && mIdx < mLimit) begin
      if (mSa == 30) wrapMem[mIdx] = w;
      else expQ.push_back('{0, modelAddr(), w, curTag});
      mIdx++;
    end
    @(negedge clk);
    rxWordValid = 1; rxWord = w;
    @(negedge clk);
    rxWordValid = 0;
    idle(3);
  endtask

  task automatic doTx();
    if (mOpen && !mFailed && mTx && mIdx < mLimit) begin
      if (mSa == 30) expQ.push_back('{2, 16'h0, wrapMem[mIdx], curTag});
      else begin
        expQ.push_back('{1, modelAddr(), 16'h0, curTag});
        expQ.push_back('{2, 16'h0, modelAddr() ^ KEY, curTag});
      end
      mIdx++;
    end
    @(negedge clk);
    txWordReq = 1;
    @(negedge clk);
    txWordReq = 0;
    idle(3);
  endtask

  task automatic doError();
    @(negedge clk); msgError = 1;
    @(negedge clk); msgError = 0;
    if (mOpen) mFailed = 1;
    idle(2);
  endtask

  task automatic doEnd();
    @(negedge clk); msgEnd = 1;
    @(negedge clk); msgEnd = 0;
    mOpen = 0;
    idle(2);
  endtask

  task automatic drained();
    idle(4);
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL %s: %0d expected events missing, expected 0", curTag, expQ.size());
      expQ.delete();
    end
  endtask

  task automatic chkReset(string name, logic [15:0] got);
    checks++;
    if (got !== 16'h0) begin
      failures++;
      $display("FAIL R1: %s=%h expected 0", name, got);
    end
  endtask

  initial begin
    rstN = 0; cmdValid = 0; cmdTx = 0; cmdSubaddr = 0; cmdWordCount = 0;
    rxWordValid = 0; rxWord = 0; txWordReq = 0; msgError = 0; msgEnd = 0;
    mOpen = 0; mFailed = 0; mTx = 0; mSa = 0; mIdx = 0; mLimit = 0;
    idle(4);
    curTag = "R1";
    chkReset("busWrite", {15'b0, busWrite});
    chkReset("busRead", {15'b0, busRead});
    chkReset("txWordValid", {15'b0, txWordValid});
    chkReset("busAddr", busAddr);
    chkReset("busDataOut", busDataOut);
    rstN = 1;
    idle(1);
    chkReset("busAddr after release", busAddr);
    running = 1;

    // R2 and R3: receive to subaddress 3, four words, then one extra (R5)
    curTag = "R2";
    doCmd(0, 3, 4);
    for (int i = 0; i < 4; i++) doRx(16'hC300 + 16'(i));
    curTag = "R5";
    doRx(16'hDEAD);
    drained();

    // R3: index restarts with a new message to another subaddress
    curTag = "R3";
    doCmd(0, 21, 2);
    doRx(16'h1111); doRx(16'h2222);
    doEnd();
    drained();

    // R4: transmit from subaddress 7, three words, then one extra
    curTag = "R4";
    doCmd(1, 7, 3);
    for (int i = 0; i < 4; i++) doTx();
    doEnd();
    drained();

    // R5: count field 0 allows 32 words, 33rd ignored
    curTag = "R5";
    doCmd(0, 1, 0);
    for (int i = 0; i < 33; i++) doRx(16'h8000 ^ 16'(i * 37));
    doEnd();
    drained();

    // R7: no message open, and wrong direction
    curTag = "R7";
    doRx(16'hBAD0);
    doTx();
    doCmd(0, 9, 2);
    doTx();
    doRx(16'h0909);
    doEnd();
    drained();

    // R6: error mid-message silences the rest until the end
    curTag = "R6";
    doCmd(0, 2, 5);
    doRx(16'hA001); doRx(16'hA002);
    doError();
    doRx(16'hA003); doRx(16'hA004);
    doEnd();
    drained();

    // R10: new command while failed resumes from index 0
    curTag = "R10";
    doCmd(1, 4, 3);
    doTx();
    doError();
    doTx();
    doCmd(1, 4, 3);
    doTx(); doTx();
    doEnd();
    drained();

    // R8: wraparound receive goes to the internal RAM only
    curTag = "R8";
    doCmd(0, 30, 4);
    for (int i = 0; i < 4; i++) doRx(16'h3E00 + 16'(i * 5));
    doEnd();
    drained();

    // R9: wraparound transmit returns the stored words
    curTag = "R9";
    doCmd(1, 30, 4);
    for (int i = 0; i < 4; i++) doTx();
    doEnd();
    drained();

    running = 0;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule